// File: doc/BRIEF.md
# Handshake-Driven Command Response Engine

This block is the byte-level protocol engine of a power-management controller. A host moves one byte at a time through a shift-register port. It signals each byte slot by pulling an active-low request line low, and the engine answers on an active-low acknowledge line. The engine watches a copy of the host port register and reacts only when that value changes. It decodes the request and acknowledge bit pair to decide whether the host is offering a byte, releasing a slot, idling or showing an illegal combination.

A transaction opens with a command byte. A per-command length table gives the number of argument bytes and the number of response bytes. Either length may be marked variable. For a variable argument length, the byte after the command carries the count. For a variable response length, the engine sends the size as its first byte. Once all arguments are in, the engine raises a one-cycle dispatch strobe toward an external handler. In that same cycle it captures the handler's reply, then streams the reply to the host one byte per request. If the host's data direction does not match the current phase, the transaction is abandoned and the engine returns to idle.

Top module: `hs_cmd_engine`

## Requirements
- R1: After reset the acknowledge output is high (released), the outgoing byte is 0x00, no dispatch strobe is active, and the remembered port value has bits 4 and 3 set, so a port held at 0x18 produces no event.
- R2: The handshake is evaluated only in a cycle where the port value differs from the value remembered at the previous evaluation. A request held at the same value for any number of cycles moves exactly one byte.
- R3: The port bits are decoded as request = bit 4 and acknowledge = bit 3, both active low. Bit 4 low with bit 3 high is a byte request. Bit 4 high with bit 3 low is a slot release and sets the acknowledge output high. Both high is idle. Both low is illegal. The idle and illegal patterns change nothing.
- R4: The acknowledge output goes low in the cycle after a byte request is seen, and it stays low until a slot release is seen.
- R5: In idle, a byte written by the host is taken as the command code. The length table, given as (arguments, response) with V meaning variable, is: 0x10 (1,0), 0x20 (V,V), 0x30 (4,0), 0x38 (0,4), 0x55 (2,3), 0x78 (0,V), 0xE0 (0,1), and every other code (0,V).
- R6: When the number of argument bytes received equals the argument length, a one-cycle dispatch strobe presents the command code, the received argument count and the stored arguments. A zero argument length dispatches right after the command byte.
- R7: For a variable argument length, the first byte after the command is the argument count. A count of zero dispatches at once.
- R8: Only the first ARG_DEPTH argument bytes are stored and the rest are discarded. The received count still advances to the full length, so the transaction completes and the reported count is the full count.
- R9: For a fixed response length N, exactly N bytes are sent in order from handler byte 0. Positions at or beyond the handler's reply length read 0x00. After the N-th byte the engine is idle.
- R10: For a variable response length, the first byte sent is the reply size, which is the handler length clamped to RSP_DEPTH. The reply bytes follow, and the engine is idle after the last one, or right after a size byte of zero.
- R11: When the handler reports the code as unknown, the response is all zeros with the table length. If that length is variable, the response is a single size byte of 0x00.
- R12: A byte request whose direction is wrong for the phase returns the engine to idle and takes no data: a host read in idle or during arguments, or a host write during the response phase.
- R13: A command with a fixed response length of zero returns to idle at dispatch and sends no bytes, so the next host write is a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_port | input | 8 | Sampled host port register; bit 4 is the request, bit 3 the acknowledge echo |
| host_writes | input | 1 | 1 when the host shifts a byte into the engine, 0 when it reads |
| host_byte | input | 8 | Byte shifted in by the host |
| ack_n | output | 1 | Active-low acknowledge to the host |
| out_byte | output | 8 | Byte offered to the host in the response phase |
| dispatch | output | 1 | One-cycle strobe: a complete command is presented |
| disp_code | output | 8 | Command code of the dispatched command |
| disp_arg_cnt | output | 8 | Number of argument bytes received |
| disp_args | output | ARG_DEPTH*8 | Stored arguments, argument 0 in the low byte |
| hnd_known | input | 1 | Handler recognises the code (sampled while dispatch is high) |
| hnd_rsp_len | input | 8 | Handler reply length in bytes |
| hnd_rsp_data | input | RSP_DEPTH*8 | Handler reply bytes, byte 0 in the low byte |

## Verification
The main function runs on transactions from every length class of the table: no arguments with a fixed reply, no arguments with a variable reply, variable arguments with an echoed reply, fixed arguments with no reply, and unknown codes with fixed and with variable lengths. Together these separate the counting paths for arguments and for the response. An echo command with more arguments than the buffer holds tells an engine that stops counting at the buffer limit from one that completes the transaction. A handler reply shorter than the table length shows whether the tail is padded with zeros. Directed sequences hold a request for many cycles, apply the idle and illegal bit pairs, reverse the data direction in each phase, and assert reset in mid-transaction. After each of these, a following command must still behave as a fresh one.

// File: rtl/cre_pkg.sv
`timescale 1ns/1ps
// Package: shared types and the per-command length table of the
// command/response engine. Assumes one byte per handshake slot.
package cre_pkg;

    localparam int BYTE_W = 8;
    localparam int LEN_W  = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARGS = 2'd1,
        ST_DISP = 2'd2,
        ST_RESP = 2'd3
    } cre_state_e;

    // A transfer length: either a fixed count or "carried in band".
    typedef struct packed {
        logic             is_var;
        logic [LEN_W-1:0] n;
    } cre_len_t;

    typedef struct packed {
        cre_len_t args;
        cre_len_t rsp;
    } cre_lens_t;

    function automatic cre_len_t fixed_len(input int unsigned n);
        cre_len_t r;
        r.is_var = 1'b0;
        r.n      = LEN_W'(n);
        return r;
    endfunction

    function automatic cre_len_t var_len();
        cre_len_t r;
        r.is_var = 1'b1;
        r.n      = '0;
        return r;
    endfunction

    // Lengths per command code; unlisted codes take no arguments and a
    // variable-length reply.
    function automatic cre_lens_t lookup_lens(input logic [BYTE_W-1:0] code);
        cre_lens_t r;
        unique case (code)
            8'h10:   begin r.args = fixed_len(1); r.rsp = fixed_len(0); end
            8'h20:   begin r.args = var_len();    r.rsp = var_len();    end
            8'h30:   begin r.args = fixed_len(4); r.rsp = fixed_len(0); end
            8'h38:   begin r.args = fixed_len(0); r.rsp = fixed_len(4); end
            8'h55:   begin r.args = fixed_len(2); r.rsp = fixed_len(3); end
            8'h78:   begin r.args = fixed_len(0); r.rsp = var_len();    end
            8'hE0:   begin r.args = fixed_len(0); r.rsp = fixed_len(1); end
            default: begin r.args = fixed_len(0); r.rsp = var_len();    end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cre_hs_decode.sv
`timescale 1ns/1ps
// Handshake decoder: remembers the last evaluated port value and, on a
// change, classifies the request/acknowledge bit pair. Assumes the port
// input is already synchronous to clk. While hold is high no change is
// consumed, so an event arriving then is evaluated once hold drops.
module cre_hs_decode #(
    parameter int PORT_W  = 8,
    parameter int REQ_BIT = 4,
    parameter int ACK_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port,
    input  logic              hold,
    output logic              ev_valid,
    output logic              ev_release
);
    localparam logic [PORT_W-1:0] RST_PORT =
        (PORT_W'(1) << REQ_BIT) | (PORT_W'(1) << ACK_BIT);

    logic [PORT_W-1:0] last_q;
    logic              changed;

    // Change detection against the remembered value.
    always_comb begin
        changed    = (port != last_q) && !hold;
        ev_valid   = changed && !port[REQ_BIT] &&  port[ACK_BIT];
        ev_release = changed &&  port[REQ_BIT] && !port[ACK_BIT];
    end

    // Remember the value that was evaluated.
    always_ff @(posedge clk) begin
        if (!rst_n)       last_q <= RST_PORT;
        else if (!hold)   last_q <= port;
    end
endmodule

// File: rtl/cre_arg_store.sv
`timescale 1ns/1ps
// Argument store: DEPTH byte slots written by index. Writes whose index
// is at or beyond DEPTH hit no slot and are dropped. clr zeroes all slots.
module cre_arg_store #(
    parameter int DEPTH = 4,
    parameter int IDX_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wr,
    input  logic [IDX_W-1:0]   idx,
    input  logic [7:0]         wr_data,
    output logic [DEPTH*8-1:0] flat
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [7:0] slot_q;
        // One slot: cleared at transaction start, written on index match.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)                       slot_q <= '0;
            else if (wr && idx == IDX_W'(i))         slot_q <= wr_data;
        end
        assign flat[i*8 +: 8] = slot_q;
    end
endmodule

// File: rtl/cre_rsp_store.sv
`timescale 1ns/1ps
// Response store: captures a handler reply of up to DEPTH bytes with its
// length and returns the byte at a read index, or zero where the index is
// at or past the captured length.
module cre_rsp_store #(
    parameter int DEPTH = 4,
    parameter int IDX_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [IDX_W-1:0]   load_len,
    input  logic [DEPTH*8-1:0] load_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [7:0]         rd_data
);
    logic [7:0]       slot_q [DEPTH];
    logic [IDX_W-1:0] len_q;

    // Reply length register.
    always_ff @(posedge clk) begin
        if (!rst_n)     len_q <= '0;
        else if (load)  len_q <= load_len;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // One reply byte captured at load.
        always_ff @(posedge clk) begin
            if (!rst_n)     slot_q[i] <= '0;
            else if (load)  slot_q[i] <= load_data[i*8 +: 8];
        end
    end

    // Indexed read with zero fill beyond the reply.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == IDX_W'(i) && IDX_W'(i) < len_q) rd_data = slot_q[i];
        end
    end
endmodule

// File: rtl/hs_cmd_engine.sv
`timescale 1ns/1ps
// Command/response engine top. Takes a command byte and its arguments
// under a request/acknowledge handshake, presents the command to a handler
// for one cycle, captures the reply in that cycle and streams it back.
// Assumes the handler answers combinationally while dispatch is high.
module hs_cmd_engine
    import cre_pkg::*;
#(
    parameter int ARG_DEPTH = 4,
    parameter int RSP_DEPTH = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [7:0]             host_port,
    input  logic                   host_writes,
    input  logic [7:0]             host_byte,
    output logic                   ack_n,
    output logic [7:0]             out_byte,
    output logic                   dispatch,
    output logic [7:0]             disp_code,
    output logic [7:0]             disp_arg_cnt,
    output logic [ARG_DEPTH*8-1:0] disp_args,
    input  logic                   hnd_known,
    input  logic [7:0]             hnd_rsp_len,
    input  logic [RSP_DEPTH*8-1:0] hnd_rsp_data
);
    localparam logic [LEN_W-1:0] RSP_CAP = LEN_W'(RSP_DEPTH);

    cre_state_e       st;
    logic             ev_valid, ev_release;
    logic [7:0]       cmd_q;
    cre_len_t         rsp_len_q;
    logic [LEN_W-1:0] arg_target_q, arg_cnt_q;
    logic             arg_need_cnt_q;
    logic [LEN_W-1:0] rsp_pos_q, rsp_size_q;
    logic             len_due_q;
    cre_lens_t        tbl;
    logic             arg_clr, arg_wr, rsp_load;
    logic [LEN_W-1:0] arg_cnt_nx, rsp_pos_nx;
    logic [LEN_W-1:0] hnd_len_clamped, rsp_load_len;
    logic [7:0]       rsp_rd;

    cre_hs_decode #(.PORT_W(8), .REQ_BIT(4), .ACK_BIT(3)) u_hs (
        .clk(clk), .rst_n(rst_n), .port(host_port), .hold(st == ST_DISP),
        .ev_valid(ev_valid), .ev_release(ev_release)
    );

    // Per-command lengths for the byte currently offered.
    always_comb tbl = lookup_lens(host_byte);

    // Strobes and next counts shared by the FSM and the stores.
    always_comb begin
        arg_clr         = ev_valid && st == ST_IDLE && host_writes;
        arg_wr          = ev_valid && st == ST_ARGS && host_writes && !arg_need_cnt_q;
        rsp_load        = st == ST_DISP;
        arg_cnt_nx      = arg_cnt_q + LEN_W'(1);
        rsp_pos_nx      = rsp_pos_q + LEN_W'(1);
        hnd_len_clamped = (hnd_rsp_len > RSP_CAP) ? RSP_CAP : hnd_rsp_len;
        rsp_load_len    = hnd_known ? hnd_len_clamped : '0;
    end

    cre_arg_store #(.DEPTH(ARG_DEPTH), .IDX_W(LEN_W)) u_args (
        .clk(clk), .rst_n(rst_n), .clr(arg_clr), .wr(arg_wr),
        .idx(arg_cnt_q), .wr_data(host_byte), .flat(disp_args)
    );

    cre_rsp_store #(.DEPTH(RSP_DEPTH), .IDX_W(LEN_W)) u_rsp (
        .clk(clk), .rst_n(rst_n), .load(rsp_load), .load_len(rsp_load_len),
        .load_data(hnd_known ? hnd_rsp_data : '0),
        .rd_idx(rsp_pos_q), .rd_data(rsp_rd)
    );

    // Acknowledge: low after a request, high after a release.
    always_ff @(posedge clk) begin
        if (!rst_n)          ack_n <= 1'b1;
        else if (ev_valid)   ack_n <= 1'b0;
        else if (ev_release) ack_n <= 1'b1;
    end

    // Transaction sequencer: command, arguments, dispatch, response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st             <= ST_IDLE;
            cmd_q          <= '0;
            rsp_len_q      <= '0;
            arg_target_q   <= '0;
            arg_cnt_q      <= '0;
            arg_need_cnt_q <= 1'b0;
            rsp_pos_q      <= '0;
            rsp_size_q     <= '0;
            len_due_q      <= 1'b0;
            out_byte       <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (ev_valid && host_writes) begin
                    cmd_q          <= host_byte;
                    rsp_len_q      <= tbl.rsp;
                    arg_target_q   <= tbl.args.n;
                    arg_need_cnt_q <= tbl.args.is_var;
                    arg_cnt_q      <= '0;
                    st <= (!tbl.args.is_var && tbl.args.n == '0) ? ST_DISP : ST_ARGS;
                end
                ST_ARGS: if (ev_valid) begin
                    if (!host_writes) begin
                        st <= ST_IDLE;
                    end else if (arg_need_cnt_q) begin
                        arg_target_q   <= host_byte;
                        arg_need_cnt_q <= 1'b0;
                        if (host_byte == '0) st <= ST_DISP;
                    end else begin
                        arg_cnt_q <= arg_cnt_nx;
                        if (arg_cnt_nx == arg_target_q) st <= ST_DISP;
                    end
                end
                ST_DISP: begin
                    rsp_pos_q  <= '0;
                    len_due_q  <= rsp_len_q.is_var;
                    rsp_size_q <= rsp_len_q.is_var ? rsp_load_len : rsp_len_q.n;
                    st <= (!rsp_len_q.is_var && rsp_len_q.n == '0) ? ST_IDLE : ST_RESP;
                end
                ST_RESP: if (ev_valid) begin
                    if (host_writes) begin
                        st <= ST_IDLE;
                    end else if (len_due_q) begin
                        out_byte  <= rsp_size_q;
                        len_due_q <= 1'b0;
                        if (rsp_size_q == '0) st <= ST_IDLE;
                    end else begin
                        out_byte  <= rsp_rd;
                        rsp_pos_q <= rsp_pos_nx;
                        if (rsp_pos_nx >= rsp_size_q) st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign dispatch     = st == ST_DISP;
    assign disp_code    = cmd_q;
    assign disp_arg_cnt = arg_cnt_q;
endmodule

// File: rtl/hs_cmd_engine_chk.sv
`timescale 1ns/1ps
// Checker for the command/response engine, bound into every instance.
module hs_cmd_engine_chk
    import cre_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ack_n,
    input logic       dispatch,
    input logic       ev_valid,
    input logic       ev_release,
    input logic       host_writes,
    input logic [7:0] out_byte,
    input cre_state_e st
);
    // R4: a byte request pulls the acknowledge low next cycle.
    p_ack_after_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |=> !ack_n);

    // R3: a slot release lets the acknowledge go high next cycle.
    p_ack_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_release |=> ack_n);

    // R2: without an event the acknowledge does not move.
    p_ack_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_valid || ev_release) |=> $stable(ack_n));

    // R6: the dispatch strobe lasts one cycle and consumes no host event.
    p_disp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch |=> !dispatch);
    p_disp_no_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch |-> !(ev_valid || ev_release));

    // R12: a host read during arguments or a write during the reply aborts.
    p_abort_args_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARGS && ev_valid && !host_writes) |=> st == ST_IDLE);
    p_abort_resp_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RESP && ev_valid && host_writes) |=> st == ST_IDLE);

    // R9: the outgoing byte only changes on a read request in the reply phase.
    p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(st == ST_RESP && ev_valid && !host_writes) |=> $stable(out_byte));
endmodule

bind hs_cmd_engine hs_cmd_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .dispatch(dispatch),
    .ev_valid(ev_valid), .ev_release(ev_release), .host_writes(host_writes),
    .out_byte(out_byte), .st(st)
);

// File: tb/hs_cmd_engine_test.sv
`timescale 1ns/1ps
// Bench for hs_cmd_engine: a vector table of whole transactions, then
// directed sequences for reset, held requests, bit-pair decoding and
// direction errors. The handler is modelled here from the requirements.
module hs_cmd_engine_test;
    localparam int AD = 4;
    localparam int RD = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    host_port = 8'h18;
    logic          host_writes = 1'b0;
    logic [7:0]    host_byte = 8'h00;
    logic          ack_n, dispatch;
    logic [7:0]    out_byte, disp_code, disp_arg_cnt;
    logic [AD*8-1:0] disp_args;
    logic          hnd_known;
    logic [7:0]    hnd_rsp_len;
    logic [RD*8-1:0] hnd_rsp_data;

    int total = 0;
    int bad   = 0;
    int n_disp = 0;
    logic [7:0] cap_code, cap_cnt, rx;
    bit done = 0;

    always #2 clk = ~clk;

    hs_cmd_engine #(.ARG_DEPTH(AD), .RSP_DEPTH(RD)) uut (
        .clk(clk), .rst_n(rst_n), .host_port(host_port),
        .host_writes(host_writes), .host_byte(host_byte), .ack_n(ack_n),
        .out_byte(out_byte), .dispatch(dispatch), .disp_code(disp_code),
        .disp_arg_cnt(disp_arg_cnt), .disp_args(disp_args),
        .hnd_known(hnd_known), .hnd_rsp_len(hnd_rsp_len),
        .hnd_rsp_data(hnd_rsp_data)
    );

    // Handler model: known codes and their replies.
    always_comb begin
        hnd_known = 1'b1; hnd_rsp_len = 8'd0; hnd_rsp_data = '0;
        case (disp_code)
            8'h38: begin hnd_rsp_len = 8'd3; hnd_rsp_data = 32'h44332211; end
            8'hE0: begin hnd_rsp_len = 8'd1; hnd_rsp_data = 32'h0000005A; end
            8'h78: begin hnd_rsp_len = 8'd2; hnd_rsp_data = 32'h0000A2A1; end
            8'h20: begin
                hnd_rsp_len  = (disp_arg_cnt > 8'd4) ? 8'd4 : disp_arg_cnt;
                hnd_rsp_data = disp_args;
            end
            8'h10, 8'h30: hnd_rsp_len = 8'd0;
            default: hnd_known = 1'b0;
        endcase
    end

    // Dispatch monitor.
    always @(posedge clk) if (rst_n && dispatch) begin
        n_disp   <= n_disp + 1;
        cap_code <= disp_code;
        cap_cnt  <= disp_arg_cnt;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // One byte slot: request, hold, sample, release, idle.
    task automatic slot(input logic w, input logic [7:0] b, input int hold);
        @(negedge clk);
        host_writes = w; host_byte = b; host_port = 8'h08;
        repeat (hold) @(negedge clk);
        check("R4 ack low", ack_n, 1'b0);
        rx = out_byte;
        host_port = 8'h10;
        repeat (3) @(negedge clk);
        check("R3 ack released", ack_n, 1'b1);
        host_port = 8'h18;
        repeat (2) @(negedge clk);
    endtask

    typedef struct packed {
        logic [7:0]      code;
        logic [3:0]      ns;
        logic [6:0][7:0] sb;   // byte 0 in the low bits
        logic [3:0]      nr;
        logic [5:0][7:0] rb;   // byte 0 in the low bits
        logic [7:0]      cnt;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'h38, 4'd0, 56'h0,              4'd4, 48'h000000332211, 8'd0}, // R9 pad
        '{8'hE0, 4'd0, 56'h0,              4'd1, 48'h00000000005A, 8'd0}, // R9
        '{8'h78, 4'd0, 56'h0,              4'd3, 48'h000000A2A102, 8'd0}, // R10
        '{8'h20, 4'd4, 56'h00000003020103, 4'd4, 48'h000003020103, 8'd3}, // R7 R10
        '{8'h20, 4'd7, 56'h04050607080906, 4'd5, 48'h000607080904, 8'd6}, // R8
        '{8'h55, 4'd2, 56'h0000000000BBAA, 4'd3, 48'h000000000000, 8'd2}, // R11
        '{8'h99, 4'd0, 56'h0,              4'd1, 48'h000000000000, 8'd0}, // R11 R5
        '{8'h30, 4'd4, 56'h00000004030201, 4'd0, 48'h000000000000, 8'd4}, // R6 R13
        '{8'h20, 4'd1, 56'h0,              4'd1, 48'h000000000000, 8'd0}  // R7 zero
    };

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int d0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ack_n", ack_n, 1'b1);
        check("R1 out_byte", out_byte, 8'h00);
        check("R1 dispatch", dispatch, 1'b0);

        // Vector walk: R5 R6 R7 R8 R9 R10 R11
        for (int v = 0; v < NV; v++) begin
            d0 = n_disp;
            slot(1'b1, VECS[v].code, 3);
            for (int i = 0; i < int'(VECS[v].ns); i++) slot(1'b1, VECS[v].sb[i], 3);
            check("R6 dispatch count", n_disp - d0, 1);
            check("R5 dispatched code", cap_code, VECS[v].code);
            check("R8 arg count", cap_cnt, VECS[v].cnt);
            for (int i = 0; i < int'(VECS[v].nr); i++) begin
                slot(1'b0, 8'h00, 3);
                check("R9 R10 R11 reply byte", rx, VECS[v].rb[i]);
            end
        end

        // R2: held request moves one byte only
        slot(1'b1, 8'h38, 3);
        slot(1'b0, 8'h00, 3);  check("R2 first", rx, 8'h11);
        slot(1'b0, 8'h00, 25); check("R2 held", rx, 8'h22);
        slot(1'b0, 8'h00, 3);  check("R2 next", rx, 8'h33);
        slot(1'b0, 8'h00, 3);  check("R9 tail", rx, 8'h00);

        // R3: illegal pair and bare release change nothing
        @(negedge clk); host_port = 8'h00; host_writes = 1'b1; host_byte = 8'h38;
        repeat (4) @(negedge clk); check("R3 illegal ack", ack_n, 1'b1);
        host_port = 8'h18; repeat (3) @(negedge clk);
        host_port = 8'h10; repeat (3) @(negedge clk); check("R3 bare release", ack_n, 1'b1);
        host_port = 8'h18; repeat (3) @(negedge clk);
        slot(1'b1, 8'hE0, 3); slot(1'b0, 8'h00, 3); check("R3 still idle", rx, 8'h5A);

        // R12: read in idle
        slot(1'b0, 8'h00, 3);
        slot(1'b1, 8'hE0, 3); slot(1'b0, 8'h00, 3); check("R12 idle read", rx, 8'h5A);
        // R12: read during arguments
        d0 = n_disp;
        slot(1'b1, 8'h30, 3); slot(1'b1, 8'h01, 3); slot(1'b0, 8'h00, 3);
        check("R12 args abort no dispatch", n_disp - d0, 0);
        slot(1'b1, 8'hE0, 3); slot(1'b0, 8'h00, 3); check("R12 after args abort", rx, 8'h5A);
        // R12: write during response
        slot(1'b1, 8'h38, 3); slot(1'b0, 8'h00, 3); check("R12 resp first", rx, 8'h11);
        slot(1'b1, 8'hE0, 3);
        slot(1'b1, 8'hE0, 3); slot(1'b0, 8'h00, 3); check("R12 resp abort", rx, 8'h5A);

        // R13: fixed zero-length reply returns to idle
        d0 = n_disp;
        slot(1'b1, 8'h10, 3); slot(1'b1, 8'h77, 3);
        check("R13 dispatched", n_disp - d0, 1);
        check("R13 code", cap_code, 8'h10);
        slot(1'b1, 8'hE0, 3); slot(1'b0, 8'h00, 3); check("R13 next cmd", rx, 8'h5A);

        // R1: reset mid-transaction
        slot(1'b1, 8'h38, 3);
        @(negedge clk); host_port = 8'h08; host_writes = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0; host_port = 8'h18;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 ack after reset", ack_n, 1'b1);
        check("R1 out after reset", out_byte, 8'h00);
        slot(1'b1, 8'hE0, 3); slot(1'b0, 8'h00, 3); check("R1 fresh cmd", rx, 8'h5A);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule